// File: doc/BRIEF.md
# Unanchored One-Hot Pattern Scanner

This block scans a byte stream at one character per clock. It raises a pulse whenever the bytes seen so far end with a string that fits a pattern fixed at elaboration. A shared decoder turns the current byte into 256 one-hot character flags. A chain of primitive blocks consumes those flags. Each block keeps one flip-flop per pattern position, and any number of positions may be live at once.

The start of the pattern is offered on every accepted byte. As a result, a match may begin at any offset, and overlapping occurrences are all reported without any loss of throughput. The default pattern is `ab[0-9]+-?_*.{3}(x|y)`:

- a two-byte literal;
- one or more members of a digit class;
- an optional dash;
- any number of underscores;
- exactly three bytes of any value;
- one of two final characters.

The exact repeat is a gated delay chain, not a set of unrolled element blocks.

The input has a valid strobe and no back-pressure. The block accepts a byte on every cycle in which `in_valid` is high. A low `in_valid` freezes all pattern state.

Top module: `nfa_pattern_matcher`

## Requirements
- R1: After a byte completes the pattern `ab[0-9]+-?_*.{3}(x|y)`, `match_o` is high in the following cycle, and only then.
- R2: The pattern is unanchored. A match may start at any earlier accepted byte, and overlapping or back-to-back occurrences are each reported.
- R3: The class element needs at least one byte in 0x30..0x39 and takes any number of them. A literal followed directly by a non-digit gives no match.
- R4: The dash (0x2D) element is optional. The pattern matches with zero or one dash, but not with two.
- R5: The underscore (0x5F) element may appear any number of times, including none.
- R6: The repeat element takes exactly REP_N (3) bytes of any value between the last underscore or earlier element and the final character.
- R7: The final byte must be 0x78 ('x') or 0x79 ('y'). Any other byte in that position gives no match.
- R8: While `in_valid` is low, no state changes and `match_o` is low. Gaps of invalid cycles are invisible to matching.
- R9: A synchronous reset clears all pattern state. `match_o` is low during and right after reset, and bytes before the reset never take part in a later match.
- R10: `match_o` is a registered pulse. It is high for one cycle per completing byte and returns low on the next cycle unless that byte also completes a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Input character |
| match_o | output | 1 | High the cycle after a byte that completes the pattern |

## Verification
The bench compares every output cycle against a backward-searching model of the pattern that tries every start position. It drives the cases where a faulty build would go astray:

- A class that accepts zero digits would report `ab---x`-style strings.
- A repeat chain one stage off would flag strings with two or four filler bytes.
- An optional element built as a star would accept a double dash.
- A design that ignores `in_valid` would break on streams with gaps.
- A reset that misses a stage would let a prefix sent before reset complete afterwards.
- Overlapping and back-to-back strings check that matches starting at every position are tracked at once, not one attempt at a time.

// File: rtl/matcher_pkg.sv
package matcher_pkg;

  localparam int unsigned ALPHA = 256;

  typedef enum logic [1:0] {
    EL_ONE  = 2'd0,
    EL_PLUS = 2'd1,
    EL_STAR = 2'd2,
    EL_OPT  = 2'd3
  } elem_mode_e;

  function automatic logic [ALPHA-1:0] range_mask(input logic [7:0] lo, input logic [7:0] hi);
    logic [ALPHA-1:0] m;
    m = '0;
    for (int i = 0; i < ALPHA; i++) begin
      if (i >= int'(lo) && i <= int'(hi)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/byte_decoder.sv
module byte_decoder
  import matcher_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       byte_i,
  output logic [ALPHA-1:0] flags_o
);

  always_comb begin
    flags_o = '0;
    flags_o[byte_i] = 1'b1;
  end

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(flags_o) == 1); // R1

endmodule

// File: rtl/nfa_elem.sv
module nfa_elem
  import matcher_pkg::*;
#(
  parameter elem_mode_e MODE = EL_ONE
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic act_i,
  input  logic hit_i,
  output logic done_o
);

  logic st_q;
  logic st_d;

  generate
    if (MODE == EL_PLUS || MODE == EL_STAR) begin : g_loop
      assign st_d = (act_i | st_q) & hit_i;
    end else begin : g_single
      assign st_d = act_i & hit_i;
    end
    if (MODE == EL_STAR || MODE == EL_OPT) begin : g_skip
      assign done_o = st_q | act_i;
    end else begin : g_noskip
      assign done_o = st_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) st_q <= 1'b0;
    else if (adv_i) st_q <= st_d;
  end

  AST_ELEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(st_q)); // R8

  AST_ELEM_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hit_i) |=> !st_q); // R3

endmodule

// File: rtl/nfa_literal.sv
module nfa_literal
  import matcher_pkg::*;
#(
  parameter int unsigned        LEN = 2,
  parameter logic [8*LEN-1:0]   STR = "ab"
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             act_i,
  input  logic [ALPHA-1:0] flags_i,
  output logic             done_o
);

  logic [LEN:0] link;
  assign link[0] = act_i;

  for (genvar i = 0; i < LEN; i++) begin : g_char
    localparam logic [7:0] CH = STR[8*(LEN-1-i) +: 8];
    nfa_elem #(.MODE(EL_ONE)) u_el (
      .clk    (clk),
      .rst    (rst),
      .adv_i  (adv_i),
      .act_i  (link[i]),
      .hit_i  (flags_i[CH]),
      .done_o (link[i+1])
    );
  end

  assign done_o = link[LEN];

endmodule

// File: rtl/nfa_repeat.sv
module nfa_repeat #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic act_i,
  input  logic hit_i,
  output logic done_o
);

  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else if (adv_i) sr_q[0] <= act_i & hit_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr_q[i] <= 1'b0;
      else if (adv_i) sr_q[i] <= sr_q[i-1] & hit_i;
    end
  end

  assign done_o = sr_q[DEPTH-1];

  AST_REP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(sr_q)); // R8

  AST_REP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hit_i) |=> (sr_q == '0)); // R6

endmodule

// File: rtl/nfa_pattern_matcher.sv
module nfa_pattern_matcher
  import matcher_pkg::*;
#(
  parameter int unsigned      LIT_LEN = 2,
  parameter logic [8*LIT_LEN-1:0] LIT = "ab",
  parameter logic [7:0]       CLS_LO  = 8'h30,
  parameter logic [7:0]       CLS_HI  = 8'h39,
  parameter logic [7:0]       OPT_CH  = 8'h2D,
  parameter logic [7:0]       STAR_CH = 8'h5F,
  parameter int unsigned      REP_N   = 3,
  parameter logic [7:0]       ALT_A   = 8'h78,
  parameter logic [7:0]       ALT_B   = 8'h79
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       match_o
);

  localparam logic [ALPHA-1:0] CLS_MASK = range_mask(CLS_LO, CLS_HI);

  logic [ALPHA-1:0] flags;
  logic cls_hit, dot_hit, alt_hit;
  logic lit_done, cls_done, opt_done, star_done, rep_done;
  logic match_q;

  byte_decoder u_dec (
    .clk     (clk),
    .rst     (rst),
    .byte_i  (in_byte),
    .flags_o (flags)
  );

  assign cls_hit = |(flags & CLS_MASK);
  assign dot_hit = |flags;
  assign alt_hit = flags[ALT_A] | flags[ALT_B];

  nfa_literal #(.LEN(LIT_LEN), .STR(LIT)) u_lit (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (in_valid),
    .act_i   (1'b1),
    .flags_i (flags),
    .done_o  (lit_done)
  );

  nfa_elem #(.MODE(EL_PLUS)) u_cls (
    .clk (clk), .rst (rst), .adv_i (in_valid),
    .act_i (lit_done), .hit_i (cls_hit), .done_o (cls_done)
  );

  nfa_elem #(.MODE(EL_OPT)) u_opt (
    .clk (clk), .rst (rst), .adv_i (in_valid),
    .act_i (cls_done), .hit_i (flags[OPT_CH]), .done_o (opt_done)
  );

  nfa_elem #(.MODE(EL_STAR)) u_star (
    .clk (clk), .rst (rst), .adv_i (in_valid),
    .act_i (opt_done), .hit_i (flags[STAR_CH]), .done_o (star_done)
  );

  nfa_repeat #(.DEPTH(REP_N)) u_rep (
    .clk (clk), .rst (rst), .adv_i (in_valid),
    .act_i (star_done), .hit_i (dot_hit), .done_o (rep_done)
  );

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else match_q <= in_valid & rep_done & alt_hit;
  end

  assign match_o = match_q;

  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(in_valid)); // R8

  AST_MATCH_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !match_o); // R9

  AST_UNION_CHAR: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(alt_hit)); // R7

endmodule

// File: tb/sim_nfa_pattern_matcher.sv
module sim_nfa_pattern_matcher;

  localparam time CLK_P = 10ns;
  localparam int  REP_N = 3;
  localparam int  HMAX  = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       match_o;

  int n_chk = 0;
  int n_bad = 0;
  byte hist [HMAX];
  int  hn = 0;

  always #(CLK_P/2) clk = ~clk;

  nfa_pattern_matcher u0 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .match_o  (match_o)
  );

  function automatic bit is_dig(byte c);
    return (c >= 8'h30 && c <= 8'h39);
  endfunction

  // Does the accepted history end, at index e, with a full pattern occurrence?
  function automatic bit model_end(int e);
    int p, q, r;
    if (!(hist[e] == "x" || hist[e] == "y")) return 0;
    p = e - 1 - REP_N;
    if (p < 0) return 0;
    for (int k = 0; k <= p + 1; k++) begin
      if (k > 0 && hist[p-k+1] != "_") break;
      q = p - k;
      for (int o = 0; o < 2; o++) begin
        if (o == 1) begin
          if (q < 0 || hist[q] != "-") continue;
          r = q - 1;
        end else r = q;
        for (int j = 1; r - j - 1 >= 0; j++) begin
          if (!is_dig(hist[r-j+1])) break;
          if (hist[r-j] == "b" && hist[r-j-1] == "a") return 1;
        end
      end
    end
    return 0;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input byte b, input string tag);
    bit exp;
    in_valid = v;
    in_byte  = b;
    exp = 1'b0;
    if (v && hn < HMAX) begin
      hist[hn] = b;
      hn++;
      exp = model_end(hn - 1);
    end
    @(negedge clk);
    check(match_o, exp, tag);
  endtask

  task automatic send(input string s, input string tag);
    foreach (s[i]) step(1'b1, s[i], tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(match_o, 1'b0, tag);
    @(negedge clk);
    rst = 1'b0;
    hn = 0;
    @(negedge clk);
    check(match_o, 1'b0, tag);
  endtask

  task automatic t_basic();
    do_reset("R9");
    send("ab5-_qqqx", "R1");
    send("ab42qrsy", "R1");
    step(1'b1, "x", "R10");
    step(1'b1, "q", "R10");
  endtask

  task automatic t_overlap();
    do_reset("R9");
    send("zzab1ab2qqqx", "R2");
    send("ab1abcy", "R2");
    send("ab1xxxxyx", "R2");
  endtask

  task automatic t_class();
    do_reset("R9");
    send("ab-_qqqx", "R3");
    send("ab_qqqx", "R3");
    send("ab9876543210qqqy", "R3");
  endtask

  task automatic t_opt();
    do_reset("R9");
    send("ab7qqqx", "R4");
    send("ab7-qqqx", "R4");
    send("ab7--_abcx", "R4");
  endtask

  task automatic t_star();
    do_reset("R9");
    send("ab3______pqrx", "R5");
    send("ab3-__-_pqry", "R5");
  endtask

  task automatic t_repeat();
    do_reset("R9");
    send("ab8pqx", "R6");
    send("ab8pqrsx", "R6");
    send("ab8\x01\xff\x80y", "R6");
  endtask

  task automatic t_union();
    do_reset("R9");
    send("ab1qqqz", "R7");
    send("ab1qqqX", "R7");
    send("ab1qqqy", "R7");
  endtask

  task automatic t_gaps();
    string s;
    do_reset("R9");
    s = "ab5-_qqqx";
    foreach (s[i]) begin
      step(1'b1, s[i], "R8");
      step(1'b0, "x", "R8");
      step(1'b0, "a", "R8");
    end
    step(1'b0, "y", "R8");
  endtask

  task automatic t_reset_mid();
    do_reset("R9");
    send("ab5-_qq", "R9");
    do_reset("R9");
    send("qx", "R9");
    send("ab5qqqx", "R9");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_basic();
    t_overlap();
    t_class();
    t_opt();
    t_star();
    t_repeat();
    t_union();
    t_gaps();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule